// File: doc/BRIEF.md
# Framed Serial Link to a Signal Processor

This block runs a full-duplex, word-framed serial connection to an external signal processor. One serial clock times everything. To start an exchange, the host pulses `frame_go`. The block then raises a one-cycle outgoing sync. After that it shifts out a fixed frame of 52 sixteen-bit words, most significant bit first. It pulls each word from a ready/valid input. If a word is missing when its slot begins, the block sends zeros in that slot and latches an underrun flag.

The receive side watches the incoming sync for a rising edge. The first data bit arrives one clock after that edge. The receiver then collects 84 sixteen-bit words, also most significant bit first. It presents each word with a one-cycle valid strobe and marks the final word as last. If a fresh sync edge arrives mid-frame, the partial frame is thrown away, an error flag is latched, and counting starts over.

The interrupt line rises when an exchange starts. It stays high through the transmit frame and through the next receive frame that ends after transmission is over. For this reason the processor should treat it as edge-triggered. Clearing `link_en` tells the block that no processor is attached, and the link then goes silent.

Top module: `dsp_frame_link`

## Requirements
- R1: A `frame_go` sampled high while `link_en` is 1 and `irq` is 0 makes `tx_fs` high for exactly one cycle, the cycle after that edge, with `tx_ready` high in the same cycle. A `frame_go` while `irq` is 1 is ignored.
- R2: The first data bit appears on `tx_sd` in the cycle after `tx_fs`. The frame is 52 words of 16 bits, sent bit 15 first, one bit per cycle. Outside the frame `tx_sd` is 0.
- R3: `tx_ready` is high during the sync cycle and during the bit-0 cycle of slots 0 to 50. At the edge that ends such a cycle, the word on `tx_data` is taken if `tx_valid` is high. `tx_ready` is 0 during the bit-0 cycle of slot 51 and after the frame.
- R4: If `tx_valid` is low while `tx_ready` is high, that slot carries sixteen zero bits and `tx_underrun` goes to 1. It stays 1 until the next accepted `frame_go`, which clears it.
- R5: A 0-to-1 change of `rx_fs` between two sampling edges starts a receive frame. The first bit is sampled at the following edge, and words are assembled bit 15 first. The cycle after a word's bit 0 is sampled, `rx_valid` is high for one cycle and `rx_data` holds the word.
- R6: `rx_last` is high together with `rx_valid` for the 84th word only. After that word the receiver waits for a new sync edge.
- R7: Only the rising edge of `rx_fs` matters. A high phase of one cycle and a high phase that spans several words both give the same received data.
- R8: A rising edge of `rx_fs` before the 84th word is complete discards the partial word, restarts counting at word 1 and sets `rx_err`. `rx_err` stays 1 until `link_en` is cleared.
- R9: `irq` is 1 from the cycle after an accepted `frame_go`, for the whole transmit frame. It drops to 0 in the cycle that shows `rx_last` for the first receive frame completed after transmission ends.
- R10: While `link_en` is 0, `tx_fs`, `tx_sd` and `irq` are 0, `frame_go` and `rx_fs` are ignored, `rx_valid` stays 0, and `rx_err` is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_en | input | 1 | Processor-attached enable |
| frame_go | input | 1 | Start an exchange |
| tx_data | input | 16 | Word to transmit |
| tx_valid | input | 1 | `tx_data` is available |
| tx_ready | output | 1 | Block takes a word at this edge |
| tx_fs | output | 1 | Outgoing frame sync |
| tx_sd | output | 1 | Outgoing serial data |
| rx_fs | input | 1 | Incoming frame sync |
| rx_sd | input | 1 | Incoming serial data |
| rx_data | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe per received word |
| rx_last | output | 1 | Marks word 84 of a frame |
| irq | output | 1 | Exchange-in-progress interrupt |
| tx_underrun | output | 1 | Sticky: a slot went out as zeros |
| rx_err | output | 1 | Sticky: a receive frame was cut short |

## Verification
The case that is hardest to reach is the interrupt release. `irq` only falls when a full 84-word receive frame finishes after all 52 transmit words are out, so one run has to cover more than two thousand cycles in two phases. The stimulus sends a complete transmit frame first. While the interrupt is still held, it tries a second start and checks that nothing happens. Only then does it feed a full receive frame, and it watches `irq` at the exact cycle `rx_last` appears. A truncated receive frame followed at once by a fresh sync is built the same way, to reach the restart-with-error path.

// File: rtl/dsp_frame_link.sv
module dsp_frame_link #(
  parameter int WORD_W   = 16,
  parameter int TX_SLOTS = 52,
  parameter int RX_SLOTS = 84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en,
  input  logic              frame_go,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_fs,
  output logic              tx_sd,
  input  logic              rx_fs,
  input  logic              rx_sd,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_last,
  output logic              irq,
  output logic              tx_underrun,
  output logic              rx_err
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int TXS_W = $clog2(TX_SLOTS);
  localparam int RXS_W = $clog2(RX_SLOTS);

  // transmit side
  logic              tfs_q, tx_run, irq_q, undr_q;
  logic [BIT_W-1:0]  tx_bit;
  logic [TXS_W-1:0]  tx_slot;
  logic [WORD_W-1:0] tx_sh;

  wire go_ok       = link_en && frame_go && !irq_q;
  wire tx_busy     = tfs_q || tx_run;
  wire tx_word_end = tx_run && (tx_bit == BIT_W'(WORD_W-1));
  wire tx_frm_end  = tx_word_end && (tx_slot == TXS_W'(TX_SLOTS-1));

  assign tx_ready    = link_en && (tfs_q || (tx_word_end && !tx_frm_end));
  assign tx_fs       = tfs_q;
  assign tx_sd       = tx_run && tx_sh[WORD_W-1];
  assign irq         = irq_q;
  assign tx_underrun = undr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tfs_q   <= 1'b0;
      tx_run  <= 1'b0;
      tx_bit  <= '0;
      tx_slot <= '0;
      tx_sh   <= '0;
    end else if (!link_en) begin
      tfs_q  <= 1'b0;
      tx_run <= 1'b0;
    end else begin
      tfs_q <= go_ok;
      if (tx_ready) begin
        tx_sh   <= tx_valid ? tx_data : '0;
        tx_bit  <= '0;
        tx_run  <= 1'b1;
        tx_slot <= tfs_q ? '0 : tx_slot + TXS_W'(1);
      end else if (tx_run) begin
        tx_sh  <= tx_sh << 1;
        tx_bit <= tx_bit + BIT_W'(1);
        if (tx_frm_end) tx_run <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    undr_q <= 1'b0;
    else if (go_ok)                undr_q <= 1'b0;
    else if (tx_ready && !tx_valid) undr_q <= 1'b1;
  end

  // receive side
  logic              fs_q, rx_run, rxv_q, rxl_q, err_q;
  logic [BIT_W-1:0]  rx_bit;
  logic [RXS_W-1:0]  rx_slot;
  logic [WORD_W-2:0] rx_sh;
  logic [WORD_W-1:0] rxd_q;

  wire fs_rise     = link_en && rx_fs && !fs_q;
  wire rx_word_end = rx_run && (rx_bit == BIT_W'(WORD_W-1));
  wire rx_frm_end  = rx_word_end && (rx_slot == RXS_W'(RX_SLOTS-1));

  assign rx_data  = rxd_q;
  assign rx_valid = rxv_q;
  assign rx_last  = rxl_q;
  assign rx_err   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) fs_q <= 1'b1;
    else        fs_q <= rx_fs;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_run  <= 1'b0;
      rx_bit  <= '0;
      rx_slot <= '0;
      rx_sh   <= '0;
      rxd_q   <= '0;
      rxv_q   <= 1'b0;
      rxl_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      rxv_q <= 1'b0;
      rxl_q <= 1'b0;
      if (!link_en) begin
        rx_run <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        if (rx_word_end && (!fs_rise || rx_frm_end)) begin
          rxd_q   <= {rx_sh, rx_sd};
          rxv_q   <= 1'b1;
          rxl_q   <= rx_frm_end;
          rx_bit  <= '0;
          rx_slot <= rx_slot + RXS_W'(1);
          if (rx_frm_end) rx_run <= 1'b0;
        end else if (rx_run) begin
          rx_sh  <= {rx_sh[WORD_W-3:0], rx_sd};
          rx_bit <= rx_bit + BIT_W'(1);
        end
        if (fs_rise) begin
          rx_run  <= 1'b1;
          rx_bit  <= '0;
          rx_slot <= '0;
          if (rx_run && !rx_frm_end) err_q <= 1'b1;
        end
      end
    end
  end

  // exchange interrupt
  always_ff @(posedge clk) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (!link_en) irq_q <= 1'b0;
    else if (go_ok)    irq_q <= 1'b1;
    else if (irq_q && !tx_busy && rx_frm_end) irq_q <= 1'b0;
  end

  // R1
  tfs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fs |=> !tx_fs);
  // R9
  irq_covers_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fs || tx_sd) |-> irq);
  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |=> (!tx_fs && !tx_sd && !irq && !rx_valid && !rx_err));
  // R5
  rx_strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R6
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_last |-> rx_valid);
  // R4
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_underrun && !frame_go) |=> tx_underrun);
  // R8
  rx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && link_en) |=> rx_err);
endmodule

// File: tb/dsp_frame_link_tb.sv
module dsp_frame_link_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, link_en, frame_go, tx_valid, rx_fs, rx_sd;
  logic [15:0] tx_data;
  logic tx_ready, tx_fs, tx_sd, rx_valid, rx_last, irq, tx_underrun, rx_err;
  logic [15:0] rx_data;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dsp_frame_link u_dut (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .frame_go(frame_go),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_fs(tx_fs), .tx_sd(tx_sd), .rx_fs(rx_fs), .rx_sd(rx_sd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
    .irq(irq), .tx_underrun(tx_underrun), .rx_err(rx_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int s, input int seed);
    return 16'((s * 40503 + seed * 977) ^ 16'h5A3C);
  endfunction

  task automatic do_tx(input int skip, input int seed);
    int bad_fs = 0;
    int bad_rdy = 0;
    int no_irq = 0;
    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0;
    check(tx_fs == 1'b1, "R1 sync", int'(tx_fs), 1);
    check(tx_ready == 1'b1, "R1 ready in sync cycle", int'(tx_ready), 1);
    check(irq == 1'b1, "R9 irq at start", int'(irq), 1);
    check(tx_underrun == 1'b0, "R4 cleared by go", int'(tx_underrun), 0);
    for (int s = 0; s < 52; s++) begin
      logic [15:0] got;
      logic [15:0] exp;
      exp = (s == skip) ? 16'h0000 : pat(s, seed);
      tx_valid = (s != skip);
      tx_data = pat(s, seed);
      got = '0;
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        tx_valid = 1'b0;
        got[15-b] = tx_sd;
        if (tx_fs) bad_fs++;
        if (!irq) no_irq++;
        if (tx_ready != ((b == 15) && (s < 51))) bad_rdy++;
      end
      check(got == exp, (s == skip) ? "R4 zero slot" : "R2 word", int'(got), int'(exp));
    end
    check(bad_fs == 0, "R1 single sync", bad_fs, 0);
    check(bad_rdy == 0, "R3 ready timing", bad_rdy, 0);
    check(no_irq == 0, "R9 irq held over tx", no_irq, 0);
    @(negedge clk);
    check(tx_sd == 1'b0 && tx_ready == 1'b0, "R2 idle after frame", int'({tx_sd, tx_ready}), 0);
  endtask

  task automatic do_rx(input int nwords, input int seed, input int fs_len, input bit exp_last);
    int cyc = 0;
    int extra = 0;
    int irq_drop = 0;
    rx_fs = 1'b1;
    for (int w = 0; w < nwords; w++) begin
      logic [15:0] word;
      word = pat(w, seed);
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        cyc++;
        if (b == 0 && w > 0) begin
          check(rx_valid && rx_data == pat(w-1, seed) && !rx_last, "R5 rx word",
                int'(rx_data), int'(pat(w-1, seed)));
        end else if (rx_valid) extra++;
        if (exp_last && !irq && tx_fs == 1'b0 && w < nwords) irq_drop = irq_drop;
        rx_fs = (cyc < fs_len);
        rx_sd = word[15-b];
      end
    end
    @(negedge clk);
    rx_fs = 1'b0;
    check(rx_valid && rx_data == pat(nwords-1, seed), "R5 final rx word",
          int'(rx_data), int'(pat(nwords-1, seed)));
    check(rx_last == exp_last, "R6 last flag", int'(rx_last), int'(exp_last));
    check(extra == 0, "R5 no stray strobes", extra, 0);
  endtask

  task automatic test_reset();
    check({tx_fs, tx_sd, irq, rx_valid, rx_last, tx_underrun, rx_err} == 7'b0,
          "R10 reset state", int'({tx_fs, tx_sd, irq, rx_valid, rx_last, tx_underrun, rx_err}), 0);
  endtask

  task automatic test_exchange(input int seed, input int fs_len);
    do_tx(-1, seed);
    check(tx_underrun == 1'b0, "R4 no underrun", int'(tx_underrun), 0);
    check(irq == 1'b1, "R9 irq waits for rx", int'(irq), 1);
    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0;
    check(tx_fs == 1'b0, "R1 go ignored while busy", int'(tx_fs), 0);
    do_rx(84, seed + 10, fs_len, 1'b1);
    check(irq == 1'b0, "R9 irq released on last", int'(irq), 0);
    check(rx_err == 1'b0, "R7 no error", int'(rx_err), 0);
    @(negedge clk);
    check(rx_valid == 1'b0, "R6 idle after last", int'(rx_valid), 0);
  endtask

  task automatic test_underrun();
    do_tx(7, 5);
    check(tx_underrun == 1'b1, "R4 underrun set", int'(tx_underrun), 1);
    do_rx(84, 6, 40, 1'b1);
    check(irq == 1'b0, "R9 irq released", int'(irq), 0);
    check(tx_underrun == 1'b1, "R4 underrun sticky", int'(tx_underrun), 1);
  endtask

  task automatic test_restart();
    do_rx(10, 21, 1, 1'b0);
    check(rx_err == 1'b0, "R8 no error yet", int'(rx_err), 0);
    do_rx(84, 22, 3, 1'b1);
    check(rx_err == 1'b1, "R8 error after cut frame", int'(rx_err), 1);
  endtask

  task automatic test_disabled();
    int strobes = 0;
    link_en = 1'b0;
    @(negedge clk);
    check(rx_err == 1'b0, "R10 error cleared", int'(rx_err), 0);
    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0;
    rx_fs = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      rx_fs = (i < 2);
      rx_sd = i[0];
      if (tx_fs || tx_sd || irq) strobes++;
      if (rx_valid) strobes++;
    end
    check(strobes == 0, "R10 link silent", strobes, 0);
    link_en = 1'b1;
    rx_fs = 1'b0;
    repeat (3) @(negedge clk);
    check(rx_valid == 1'b0 && irq == 1'b0, "R10 stays idle", int'({rx_valid, irq}), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; link_en = 1'b1; frame_go = 1'b0; tx_valid = 1'b0;
    tx_data = '0; rx_fs = 1'b0; rx_sd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_exchange(1, 1);
    test_underrun();
    test_exchange(3, 100);
    test_restart();
    test_disabled();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule